// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block tracks a single processor's reservation for an atomic read-modify-write sequence. An exclusive load opens a reservation and records the word it covers and the access size. A later exclusive store is judged against that reservation. If the store matches, it goes through to memory and reports success. If it does not match, the write is dropped and the store reports failure. The reservation is removed by a clear command, by exception entry, and by every exclusive store, whether or not that store succeeds. A thread that is preempted between its load and its store therefore has to retry.

Each store request returns a registered verdict one cycle later, marked by a status-valid pulse. The write strobe, address, byte enables and lane-replicated data leave the block in that same cycle. A small behavioural memory inside the block takes that strobe, and a read port lets a checker see whether the write landed. The current reservation state is visible on a flag.

Top module: `excl_monitor`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), tag_valid, st_status_vld and wr_en are 0. Reset release is synchronised over two clock edges.
- R2: An exclusive load (ld_req) with no clear or exception in the same cycle sets tag_valid from the next cycle on.
- R3: A successful store drives st_status=0 and wr_en=1 one cycle after the request. It writes st_data into the memory word at st_addr[7:2]. The byte lanes are chosen by size code (st_size 0=byte, 1=halfword, 2=word): a byte uses lane st_addr[1:0], a halfword uses lanes 3:2 when st_addr[1]=1 and lanes 1:0 otherwise, and a word uses all four lanes. The data is replicated across the lanes on wr_data.
- R4: A failed store drives st_status=1 and wr_en=0 and leaves memory unchanged.
- R5: Every exclusive store clears tag_valid, whatever its outcome, unless a load in the same cycle reopens the reservation.
- R6: A clear command (clr_req) clears tag_valid.
- R7: Exception entry (exc_entry) clears tag_valid, and a following store fails.
- R8: A store made while tag_valid is 0, including the first store after reset, fails.
- R9: Addresses are compared at word granularity. The low two bits are ignored, and a store to a different word fails.
- R10: A store whose size code differs from the reserved size fails.
- R11: A new load while a reservation is open replaces the reserved address and size.
- R12: A clear or exception in the same cycle as a store makes the store fail. A clear in the same cycle as a load leaves tag_valid at 0.
- R13: st_status_vld is a one-cycle pulse, high exactly in the cycle after each st_req and low otherwise.
- R14: When a load and a store share a cycle, the store is judged against the reservation held before that cycle, and the load's reservation is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Exclusive load pulse |
| ld_addr | input | 8 | Exclusive load byte address |
| ld_size | input | 2 | Exclusive load size code |
| st_req | input | 1 | Exclusive store pulse |
| st_addr | input | 8 | Exclusive store byte address |
| st_size | input | 2 | Exclusive store size code |
| st_data | input | 32 | Store data, right-aligned |
| clr_req | input | 1 | Clear-reservation pulse |
| exc_entry | input | 1 | Exception entry pulse |
| st_status_vld | output | 1 | Store verdict valid |
| st_status | output | 1 | Store verdict: 0 done, 1 failed |
| wr_en | output | 1 | Gated memory write strobe |
| wr_addr | output | 8 | Write byte address |
| wr_data | output | 32 | Lane-replicated write data |
| wr_be | output | 4 | Write byte enables |
| tag_valid | output | 1 | Reservation open |
| rd_addr | input | 8 | Memory read byte address |
| rd_data | output | 32 | Memory word at rd_addr |

## Verification
An exclusive store can meet a clear command, an exception entry or a new exclusive load in the same cycle. The bench raises these pulses together on one clock edge. A store meeting a clear or an exception must report failure, drop its write and leave the reservation closed. A store meeting a load is judged against the old reservation, so it succeeds while the new reservation stays open, and a follow-up store to the newly loaded word then succeeds too.

// File: rtl/excl_pkg.sv
package excl_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xsize_e;

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << lo;
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_data(input logic [1:0] sz, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    case (sz)
      SZ_BYTE: r = {4{d[7:0]}};
      SZ_HALF: r = {2{d[15:0]}};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/excl_rst_sync.sv
module excl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0, s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      s0 <= 1'b1;
      s1 <= s0;
    end
  end

  assign rst_sync_n = s1;
endmodule

// File: rtl/excl_reservation.sv
module excl_reservation #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic          st_req,
  input  logic          kill,
  output logic          tag_v,
  output logic [AW-3:0] res_word,
  output logic [1:0]    res_size
);
  logic          tag_n;
  logic [AW-3:0] word_n;
  logic [1:0]    size_n;
  logic          upd_en;
  logic [1:0]    unused_lo;

  assign unused_lo = ld_addr[1:0];

  always_comb begin
    upd_en = kill | ld_req | st_req;
    tag_n  = tag_v;
    word_n = res_word;
    size_n = res_size;
    if (kill) begin
      tag_n = 1'b0;
    end else if (ld_req) begin
      tag_n  = 1'b1;
      word_n = ld_addr[AW-1:2];
      size_n = ld_size;
    end else if (st_req) begin
      tag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tag_v    <= 1'b0;
      res_word <= '0;
      res_size <= 2'd0;
    end else if (upd_en) begin
      tag_v    <= tag_n;
      res_word <= word_n;
      res_size <= size_n;
    end
  end

  // R2
  load_opens_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ld_req && !kill) |=> tag_v);
  // R5
  store_closes_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_req && !ld_req && !kill) |=> !tag_v);
  // R6
  kill_closes_chk: assert property (@(posedge clk) disable iff (!rst_i)
    kill |=> !tag_v);
endmodule

// File: rtl/excl_judge.sv
module excl_judge #(
  parameter int AW = 8
) (
  input  logic          tag_v,
  input  logic [AW-3:0] res_word,
  input  logic [1:0]    res_size,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic          kill,
  output logic          pass
);
  logic word_hit, size_hit;

  always_comb begin
    word_hit = (st_addr[AW-1:2] == res_word);
    size_hit = (st_size == res_size);
    pass     = tag_v & word_hit & size_hit & ~kill;
  end
endmodule

// File: rtl/excl_commit.sv
module excl_commit
  import excl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              st_req,
  input  logic              kill,
  input  logic              pass,
  input  logic [AW-1:0]     st_addr,
  input  logic [1:0]        st_size,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_status_vld,
  output logic              st_status,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be
);
  logic              vld_n, stat_n, we_n;
  logic [AW-1:0]     wa_n;
  logic [DATA_W-1:0] wd_n;
  logic [LANES-1:0]  be_n;

  always_comb begin
    vld_n  = st_req;
    stat_n = st_req & ~pass;
    we_n   = st_req & pass;
    wa_n   = wr_addr;
    wd_n   = wr_data;
    be_n   = wr_be;
    if (st_req) begin
      wa_n = st_addr;
      wd_n = lane_data(st_size, st_data);
      be_n = lane_mask(st_size, st_addr[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_status_vld <= 1'b0;
      st_status     <= 1'b0;
      wr_en         <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
      wr_be         <= '0;
    end else begin
      st_status_vld <= vld_n;
      st_status     <= stat_n;
      wr_en         <= we_n;
      wr_addr       <= wa_n;
      wr_data       <= wd_n;
      wr_be         <= be_n;
    end
  end

  // R13
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_i)
    st_req |=> st_status_vld);
  // R13
  verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !st_req |=> !st_status_vld);
  // R12
  kill_fails_store_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_req && kill) |=> (st_status && !wr_en));
endmodule

// File: rtl/excl_mem.sv
module excl_mem
  import excl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 2 ** (AW - 2);

  logic [DATA_W-1:0] mem [WORDS];
  logic [3:0]        unused_lo;

  assign unused_lo = {wr_addr[1:0], rd_addr[1:0]};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int g = 0; g < LANES; g++) begin
        if (wr_be[g]) mem[wr_addr[AW-1:2]][8*g +: 8] <= wr_data[8*g +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr[AW-1:2]];
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [AW-1:0]     ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_req,
  input  logic [AW-1:0]     st_addr,
  input  logic [1:0]        st_size,
  input  logic [DATA_W-1:0] st_data,
  input  logic              clr_req,
  input  logic              exc_entry,
  output logic              st_status_vld,
  output logic              st_status,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              tag_valid,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic          rst_i;
  logic          kill;
  logic          pass;
  logic [AW-3:0] res_word;
  logic [1:0]    res_size;

  assign kill = clr_req | exc_entry;

  excl_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i)
  );

  excl_reservation #(.AW(AW)) u_res (
    .clk(clk), .rst_i(rst_i), .ld_req(ld_req), .ld_addr(ld_addr),
    .ld_size(ld_size), .st_req(st_req), .kill(kill), .tag_v(tag_valid),
    .res_word(res_word), .res_size(res_size)
  );

  excl_judge #(.AW(AW)) u_judge (
    .tag_v(tag_valid), .res_word(res_word), .res_size(res_size),
    .st_addr(st_addr), .st_size(st_size), .kill(kill), .pass(pass)
  );

  excl_commit #(.AW(AW)) u_commit (
    .clk(clk), .rst_i(rst_i), .st_req(st_req), .kill(kill), .pass(pass),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .st_status_vld(st_status_vld), .st_status(st_status), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  excl_mem #(.AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R8
  closed_store_fails_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_req && !tag_valid) |=> st_status);
  // R4
  failed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_status_vld && st_status) |-> !wr_en);
endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ld_req, st_req, clr_req, exc_entry;
  logic [7:0]  ld_addr, st_addr, rd_addr, wr_addr;
  logic [1:0]  ld_size, st_size;
  logic [31:0] st_data, wr_data, rd_data;
  logic        st_status_vld, st_status, wr_en, tag_valid;
  logic [3:0]  wr_be;

  int n_run;
  int n_fail;

  excl_monitor uut (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_req(st_req), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .clr_req(clr_req), .exc_entry(exc_entry), .st_status_vld(st_status_vld),
    .st_status(st_status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .tag_valid(tag_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic ld, st, clr, exc;
    logic [7:0] la, sa;
    logic [1:0] lsz, ssz;
    logic [31:0] d;
    logic ev, es, et;
    logic [3:0] rq;
  } vec_t;

  // size codes: 0 byte, 1 half, 2 word
  localparam vec_t VEC [28] = '{
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h10,2'd2,2'd2,32'hDEAD0001,1'b1,1'b1,1'b0,4'd8},  // R8
    '{1'b1,1'b0,1'b0,1'b0,8'h10,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h12,2'd2,2'd2,32'hCAFE0010,1'b1,1'b0,1'b0,4'd9},  // R9
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h10,2'd2,2'd2,32'h0BAD0003,1'b1,1'b1,1'b0,4'd5},  // R5
    '{1'b1,1'b0,1'b0,1'b0,8'h20,8'h00,2'd1,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h20,2'd2,2'd2,32'h0BAD0005,1'b1,1'b1,1'b0,4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b0,8'h20,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h24,2'd2,2'd2,32'h0BAD0007,1'b1,1'b1,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b0,1'b0,8'h30,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b0,4'd6},         // R6
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h30,2'd2,2'd2,32'h0BAD000A,1'b1,1'b1,1'b0,4'd6},  // R6
    '{1'b1,1'b0,1'b0,1'b0,8'h31,8'h00,2'd0,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b0,1'b0,1'b1,8'h00,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b0,4'd7},         // R7
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h31,2'd2,2'd0,32'h0BAD000D,1'b1,1'b1,1'b0,4'd7},  // R7
    '{1'b1,1'b0,1'b0,1'b0,8'h40,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b1,1'b0,1'b0,1'b0,8'h44,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd11},        // R11
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h40,2'd2,2'd2,32'h0BAD0010,1'b1,1'b1,1'b0,4'd11}, // R11
    '{1'b1,1'b0,1'b0,1'b0,8'h48,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b1,1'b0,1'b0,1'b0,8'h50,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd11},        // R11
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h50,2'd2,2'd2,32'h50505050,1'b1,1'b0,1'b0,4'd11}, // R11
    '{1'b1,1'b0,1'b0,1'b0,8'h60,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h60,2'd2,2'd2,32'h0BAD0015,1'b1,1'b1,1'b0,4'd12}, // R12
    '{1'b1,1'b0,1'b0,1'b0,8'h60,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b0,1'b1,1'b0,1'b1,8'h00,8'h60,2'd2,2'd2,32'h0BAD0017,1'b1,1'b1,1'b0,4'd12}, // R12
    '{1'b1,1'b0,1'b0,1'b0,8'h70,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b1,4'd2},         // R2
    '{1'b1,1'b1,1'b0,1'b0,8'h74,8'h70,2'd2,2'd2,32'h70707070,1'b1,1'b0,1'b1,4'd14}, // R14
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h74,2'd2,2'd2,32'h74747474,1'b1,1'b0,1'b0,4'd14}, // R14
    '{1'b1,1'b0,1'b1,1'b0,8'h78,8'h00,2'd2,2'd2,32'h0,1'b0,1'b0,1'b0,4'd12}         // R12
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_req = 0; st_req = 0; clr_req = 0; exc_entry = 0;
  endtask

  task automatic drive(input logic ld, input logic st, input logic clr, input logic exc,
                       input logic [7:0] la, input logic [7:0] sa,
                       input logic [1:0] lsz, input logic [1:0] ssz, input logic [31:0] d);
    ld_req = ld; st_req = st; clr_req = clr; exc_entry = exc;
    ld_addr = la; st_addr = sa; ld_size = lsz; st_size = ssz; st_data = d;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    idle_inputs();
    ld_addr = 0; st_addr = 0; ld_size = 0; st_size = 0; st_data = 0; rd_addr = 0;
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    // R1: outputs held low in reset
    chk(!tag_valid && !st_status_vld && !wr_en, "R1",
        {29'b0, tag_valid, st_status_vld, wr_en}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tag_valid, "R1", {31'b0, tag_valid}, 32'h0);

    for (int i = 0; i < 28; i++) begin
      vec_t v;
      string rn;
      v = VEC[i];
      rn = $sformatf("R%0d row%0d", v.rq, i);
      drive(v.ld, v.st, v.clr, v.exc, v.la, v.sa, v.lsz, v.ssz, v.d);
      chk(st_status_vld == v.ev, rn, {31'b0, st_status_vld}, {31'b0, v.ev});
      if (v.ev) chk(st_status == v.es, rn, {31'b0, st_status}, {31'b0, v.es});
      chk(tag_valid == v.et, rn, {31'b0, tag_valid}, {31'b0, v.et});
      chk(wr_en == (v.ev && !v.es), rn, {31'b0, wr_en}, {31'b0, v.ev && !v.es});
      if (v.ev && !v.es) begin
        chk(wr_addr == v.sa, rn, {24'b0, wr_addr}, {24'b0, v.sa});
        chk(wr_data == v.d && wr_be == 4'hF, rn, wr_data, v.d);
      end
    end

    // R13: verdict pulse drops after an idle cycle
    drive(0, 0, 0, 0, 0, 0, 2, 2, 0);
    chk(!st_status_vld, "R13", {31'b0, st_status_vld}, 32'h0);
    // R3: earlier successful word store landed in memory
    rd_addr = 8'h10; #1;
    chk(rd_data == 32'hCAFE0010, "R3", rd_data, 32'hCAFE0010);
    rd_addr = 8'h70; #1;
    chk(rd_data == 32'h70707070, "R14", rd_data, 32'h70707070);

    // R3: word then byte then halfword into word 0x80
    drive(1, 0, 0, 0, 8'h80, 0, 2, 2, 0);
    drive(0, 1, 0, 0, 0, 8'h80, 2, 2, 32'h11223344);
    drive(1, 0, 0, 0, 8'h81, 0, 0, 2, 0);
    drive(0, 1, 0, 0, 0, 8'h81, 2, 0, 32'h000000A5);
    chk(wr_en && wr_be == 4'b0010 && wr_data == 32'hA5A5A5A5, "R3",
        {wr_be, wr_data[27:0]}, {4'b0010, 28'h5A5A5A5});
    drive(0, 0, 0, 0, 0, 0, 2, 2, 0);
    rd_addr = 8'h80; #1;
    chk(rd_data == 32'h1122A544, "R3", rd_data, 32'h1122A544);
    drive(1, 0, 0, 0, 8'h82, 0, 1, 2, 0);
    drive(0, 1, 0, 0, 0, 8'h82, 2, 1, 32'h0000BEEF);
    chk(wr_en && wr_be == 4'b1100, "R3", {27'b0, wr_en, wr_be}, 32'h1C);
    drive(0, 0, 0, 0, 0, 0, 2, 2, 0);
    chk(rd_data == 32'hBEEFA544, "R3", rd_data, 32'hBEEFA544);

    // R4: failed store leaves memory alone
    drive(0, 1, 0, 0, 0, 8'h80, 2, 2, 32'h00000000);
    chk(st_status && !wr_en, "R4", {30'b0, st_status, wr_en}, 32'h2);
    drive(0, 0, 0, 0, 0, 0, 2, 2, 0);
    chk(rd_data == 32'hBEEFA544, "R4", rd_data, 32'hBEEFA544);

    // R1: reset drops an open reservation; R8: first store after it fails
    drive(1, 0, 0, 0, 8'h90, 0, 2, 2, 0);
    chk(tag_valid, "R2", {31'b0, tag_valid}, 32'h1);
    rst_n = 1'b0; #1;
    chk(!tag_valid && !st_status_vld, "R1", {30'b0, tag_valid, st_status_vld}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(0, 1, 0, 0, 0, 8'h90, 2, 2, 32'h99999999);
    chk(st_status_vld && st_status && !wr_en, "R8",
        {29'b0, st_status_vld, st_status, wr_en}, 32'h6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule